// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a system timer driven by a slow-clock tick enable, nominally 32768 Hz. The bus and the timer share one clock, so the block needs no clock-domain crossing. A prescaler divides the slow ticks and drives a free-running real-time counter. An alarm raises a flag when that counter reaches an absolute value. A separate periodic interval timer counts raw slow ticks and raises a flag each time its programmed period runs out.

Four status flags are combined with an interrupt mask and ORed onto one interrupt line. Software programs the block through a simple single-cycle register bus:

- Reads are combinational on `rdata_o`.
- Writes take effect at the clock edge.
- Reading the status word clears the pending flags at that edge.

The counter is normally used as a continuous time base. The alarm provides one-shot events and the interval timer provides a fixed system tick.

Top module: `sys_timer`

## Requirements
- R1: After reset the counter, alarm, period, status and mask read zero, the prescaler reads 32768, and `irq_o` is low. Word addresses are 0 counter (read only), 1 alarm, 2 period, 3 prescaler, 4 status, 5 mask set, 6 mask clear, 7 mask (read only).
- R2: The counter advances once every P slow ticks, where P is the prescaler value. A prescaler of 0 or 1 advances it on every tick. A prescaler write restarts the division phase, so the first step comes P ticks after the write.
- R3: The counter is CNT_W bits wide, steps from all ones to zero, and holds its value in any cycle without `tick_i`.
- R4: Status bit 3 (alarm) sets on the counter step that makes the counter equal to the alarm register.
- R5: An alarm written with the current counter value does not fire until the counter has gone once around its full range, 2^CNT_W steps later.
- R6: With period N greater than 0, status bit 0 (interval) sets on every Nth slow tick. A write to the period register restarts the countdown, so the first flag comes N ticks after the write. A period of 0 never sets the flag.
- R7: Status bit 2 (count step) sets on every counter step.
- R8: A status read returns the pending bits and clears them at that clock edge. An event arriving in the same cycle as the read stays pending afterwards.
- R9: A write to address 5 sets the mask bits written as one. A write to address 6 clears the mask bits written as one. Zero bits leave the mask unchanged, and address 7 reads the mask back.
- R10: `irq_o` is high exactly when some pending status bit has its mask bit set.
- R11: Status bit 1 (reserved watchdog overflow) always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared bus and timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow-clock tick enable, one cycle per slow period |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (needed for the status read-clear) |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, zero-extended |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The prescaler is swept over the values 0 to 5, and the default of 32768 is also run. Comparing the counter just before and just after each expected step catches a division that is off by one, and a phase that is not restarted on a write.

The alarm is placed 2 to 6 steps ahead of the counter, and also exactly on the current value. Together these separate a match on reaching the value from a match on simply being equal, and confirm the full-wrap delay.

The interval period is swept over 1 to 4, plus a restart case and a period of zero. A status read is issued in the same cycle as a count step, to show whether a same-cycle event survives the clear. The mask is driven with overlapping set and clear patterns, each checked through the readback and through `irq_o`.

// File: rtl/sys_timer_pkg.sv
package sys_timer_pkg;
  typedef enum logic [2:0] {
    A_COUNT   = 3'd0,
    A_ALARM   = 3'd1,
    A_PERIOD  = 3'd2,
    A_PRESC   = 3'd3,
    A_STATUS  = 3'd4,
    A_MSK_SET = 3'd5,
    A_MSK_CLR = 3'd6,
    A_MASK    = 3'd7
  } reg_addr_e;

  localparam int NST      = 4;
  localparam int BIT_PER  = 0;
  localparam int BIT_WDOG = 1;
  localparam int BIT_INC  = 2;
  localparam int BIT_ALM  = 3;
endpackage

// File: rtl/st_rtc_count.sv
module st_rtc_count #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pre_we_i,
  input  logic [PRE_W-1:0] pre_wdata_i,
  input  logic             alm_we_i,
  input  logic [CNT_W-1:0] alm_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PRE_W-1:0] pre_o,
  output logic [CNT_W-1:0] alm_o,
  output logic             inc_o,
  output logic             alm_evt_o
);
  localparam logic [PRE_W-1:0] PRE_INIT = PRE_W'(PRE_RST);

  logic [PRE_W-1:0] pre_q, phase_q;
  logic [CNT_W-1:0] cnt_q, alm_q, cnt_nxt;
  logic [PRE_W:0]   phase_nxt;
  logic             roll;

  assign phase_nxt = {1'b0, phase_q} + 1'b1;
  // value 0 treated like 1: every tick rolls
  assign roll      = tick_i && (phase_nxt >= {1'b0, pre_q});
  assign cnt_nxt   = cnt_q + 1'b1;
  assign inc_o     = roll;
  assign alm_evt_o = roll && (cnt_nxt == alm_q);
  assign cnt_o     = cnt_q;
  assign pre_o     = pre_q;
  assign alm_o     = alm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= PRE_INIT;
      phase_q <= '0;
      cnt_q   <= '0;
      alm_q   <= '0;
    end else begin
      if (pre_we_i) pre_q <= pre_wdata_i;
      if (alm_we_i) alm_q <= alm_wdata_i;
      if (pre_we_i)  phase_q <= '0;
      else if (tick_i) phase_q <= roll ? '0 : phase_nxt[PRE_W-1:0];
      if (roll) cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/st_interval.sv
module st_interval #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             per_we_i,
  input  logic [PER_W-1:0] per_wdata_i,
  output logic [PER_W-1:0] per_o,
  output logic             evt_o
);
  logic [PER_W-1:0] per_q, down_q;
  logic             armed;

  assign armed = (per_q != '0);
  assign evt_o = tick_i && armed && (down_q <= PER_W'(1));
  assign per_o = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      down_q <= '0;
    end else if (per_we_i) begin
      per_q  <= per_wdata_i;
      down_q <= per_wdata_i;
    end else if (tick_i && armed) begin
      down_q <= evt_o ? per_q : down_q - 1'b1;
    end
  end
endmodule

// File: rtl/st_status_irq.sv
module st_status_irq #(
  parameter int NST = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NST-1:0] evt_i,
  input  logic           rd_clr_i,
  input  logic           set_we_i,
  input  logic           clr_we_i,
  input  logic [NST-1:0] wdata_i,
  output logic [NST-1:0] st_o,
  output logic [NST-1:0] mask_o,
  output logic           irq_o
);
  logic [NST-1:0] st_q, mask_q;

  for (genvar b = 0; b < NST; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[b]   <= 1'b0;
        mask_q[b] <= 1'b0;
      end else begin
        // same-cycle event wins over the read clear
        st_q[b] <= (st_q[b] && !rd_clr_i) || evt_i[b];
        if (set_we_i && wdata_i[b])      mask_q[b] <= 1'b1;
        else if (clr_we_i && wdata_i[b]) mask_q[b] <= 1'b0;
      end
    end
  end

  assign st_o   = st_q;
  assign mask_o = mask_q;
  assign irq_o  = |(st_q & mask_q);
endmodule

// File: rtl/sys_timer.sv
module sys_timer
  import sys_timer_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768,
  parameter int PER_W   = 16,
  parameter int DW      = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  reg_addr_e        ra;
  logic [CNT_W-1:0] cnt_w, alm_w;
  logic [PRE_W-1:0] pre_w;
  logic [PER_W-1:0] per_w;
  logic [NST-1:0]   st_w, mask_w, evt_w;
  logic             inc_w, alm_evt_w, per_evt_w;
  logic             unused_wdata;

  assign ra           = reg_addr_e'(addr_i);
  assign unused_wdata = ^wdata_i;

  st_rtc_count #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .pre_we_i   (wr_i && ra == A_PRESC),
    .pre_wdata_i(wdata_i[PRE_W-1:0]),
    .alm_we_i   (wr_i && ra == A_ALARM),
    .alm_wdata_i(wdata_i[CNT_W-1:0]),
    .cnt_o      (cnt_w),
    .pre_o      (pre_w),
    .alm_o      (alm_w),
    .inc_o      (inc_w),
    .alm_evt_o  (alm_evt_w)
  );

  st_interval #(.PER_W(PER_W)) u_pit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .per_we_i   (wr_i && ra == A_PERIOD),
    .per_wdata_i(wdata_i[PER_W-1:0]),
    .per_o      (per_w),
    .evt_o      (per_evt_w)
  );

  always_comb begin
    evt_w           = '0;
    evt_w[BIT_PER]  = per_evt_w;
    evt_w[BIT_WDOG] = 1'b0;
    evt_w[BIT_INC]  = inc_w;
    evt_w[BIT_ALM]  = alm_evt_w;
  end

  st_status_irq #(.NST(NST)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_w),
    .rd_clr_i(rd_i && ra == A_STATUS),
    .set_we_i(wr_i && ra == A_MSK_SET),
    .clr_we_i(wr_i && ra == A_MSK_CLR),
    .wdata_i (wdata_i[NST-1:0]),
    .st_o    (st_w),
    .mask_o  (mask_w),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (ra)
      A_COUNT:  rdata_o = DW'(cnt_w);
      A_ALARM:  rdata_o = DW'(alm_w);
      A_PERIOD: rdata_o = DW'(per_w);
      A_PRESC:  rdata_o = DW'(pre_w);
      A_STATUS: rdata_o = DW'(st_w);
      A_MASK:   rdata_o = DW'(mask_w);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sys_timer_chk.sv
module sys_timer_chk
  import sys_timer_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int DW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [2:0]       addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             irq_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] alm_i,
  input logic [NST-1:0]   st_i,
  input logic [NST-1:0]   mask_i,
  input logic [NST-1:0]   evt_i
);
  logic st_rd, set_wr, clr_wr, alm_wr;
  logic unused_hi;
  assign st_rd     = rd_i && addr_i == 3'd4;
  assign set_wr    = wr_i && addr_i == 3'd5;
  assign clr_wr    = wr_i && addr_i == 3'd6;
  assign alm_wr    = wr_i && addr_i == 3'd1;
  assign unused_hi = ^wdata_i;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> cnt_i == $past(cnt_i)); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_i == $past(cnt_i)) || (cnt_i == CNT_W'($past(cnt_i) + 1'b1))); // R2
  AST_ALM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[BIT_ALM] && !alm_wr |=> cnt_i == alm_i); // R4
  AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rd |=> (st_i & ~$past(evt_i)) == '0); // R8
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> (mask_i & $past(wdata_i[NST-1:0])) == $past(wdata_i[NST-1:0])); // R9
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (mask_i & $past(wdata_i[NST-1:0])) == '0); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !st_rd && !clr_wr |=> irq_i); // R10
  AST_WDOG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_i[BIT_WDOG]); // R11
endmodule

bind sys_timer sys_timer_chk #(.CNT_W(CNT_W), .DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_i  (irq_o),
  .cnt_i  (cnt_w),
  .alm_i  (alm_w),
  .st_i   (st_w),
  .mask_i (mask_w),
  .evt_i  (evt_w)
);

// File: tb/sys_timer_tb_top.sv
module sys_timer_tb_top;
  localparam int CW = 8;
  localparam logic [31:0] CMASK = (32'd1 << CW) - 1;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sys_timer #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      tick = 1'b1; @(posedge clk); @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] v, input logic tk = 1'b0);
    rd = 1'b1; addr = a; tick = tk;
    #1 v = rdata;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd_reg(3'd0, v); check("R1 count", v, 0);
    rd_reg(3'd1, v); check("R1 alarm", v, 0);
    rd_reg(3'd2, v); check("R1 period", v, 0);
    rd_reg(3'd3, v); check("R1 prescaler", v, 32768);
    rd_reg(3'd4, v); check("R1 status", v, 0);
    rd_reg(3'd7, v); check("R1 mask", v, 0);
    check("R1 irq", irq, 0);

    // R2 default prescaler, R7 step flag
    step(32767);
    rd_reg(3'd0, v); check("R2 default before step", v, 0);
    step(1);
    rd_reg(3'd0, v); check("R2 default step", v, 1);
    rd_reg(3'd4, v); check("R7 step flag", v, 32'h4);
    rd_reg(3'd4, v); check("R8 cleared by read", v, 0);

    // R2 prescaler sweep with phase restart
    for (int p = 1; p <= 5; p++) begin
      wr_reg(3'd3, p);
      rd_reg(3'd0, c);
      step(3 * p - 1);
      rd_reg(3'd0, v); check($sformatf("R2 presc %0d early", p), v, (c + 2) & CMASK);
      step(1);
      rd_reg(3'd0, v); check($sformatf("R2 presc %0d step", p), v, (c + 3) & CMASK);
    end
    wr_reg(3'd3, 0);
    rd_reg(3'd0, c);
    step(4);
    rd_reg(3'd0, v); check("R2 presc 0", v, (c + 4) & CMASK);

    // R3 wrap and hold
    wr_reg(3'd3, 1);
    rd_reg(3'd0, c);
    step(255 - int'(c));
    rd_reg(3'd0, v); check("R3 at max", v, 255);
    idle(5);
    rd_reg(3'd0, v); check("R3 hold without tick", v, 255);
    step(1);
    rd_reg(3'd0, v); check("R3 wrap", v, 0);

    // R4 alarm sweep
    for (int d = 2; d <= 6; d++) begin
      rd_reg(3'd0, c);
      wr_reg(3'd1, (c + d) & CMASK);
      rd_reg(3'd4, v);
      step(d - 1);
      rd_reg(3'd4, v); check($sformatf("R4 alarm d=%0d early", d), v[3], 0);
      step(1);
      rd_reg(3'd4, v); check($sformatf("R4 alarm d=%0d", d), v[3], 1);
    end

    // R5 alarm equal to current value
    rd_reg(3'd0, c);
    wr_reg(3'd1, c);
    rd_reg(3'd4, v);
    step(255);
    rd_reg(3'd4, v); check("R5 no alarm before wrap", v[3], 0);
    step(1);
    rd_reg(3'd4, v); check("R5 alarm after wrap", v[3], 1);
    check("R11 watchdog bit", v[1], 0);

    // R8 event during read survives
    rd_reg(3'd4, v);
    rd_reg(3'd4, v, 1'b1); check("R8 read before event", v, 0);
    rd_reg(3'd4, v); check("R8 same-cycle event kept", v, 32'h4);

    // R6 interval sweep
    for (int p = 1; p <= 4; p++) begin
      wr_reg(3'd2, p);
      rd_reg(3'd4, v);
      if (p > 1) begin
        step(p - 1);
        rd_reg(3'd4, v); check($sformatf("R6 period %0d early", p), v[0], 0);
      end
      step(1);
      rd_reg(3'd4, v); check($sformatf("R6 period %0d first", p), v[0], 1);
      step(p);
      rd_reg(3'd4, v); check($sformatf("R6 period %0d repeat", p), v[0], 1);
    end
    wr_reg(3'd2, 5);
    step(3);
    wr_reg(3'd2, 5);
    rd_reg(3'd4, v);
    step(4);
    rd_reg(3'd4, v); check("R6 restart early", v[0], 0);
    step(1);
    rd_reg(3'd4, v); check("R6 restart fire", v[0], 1);
    wr_reg(3'd2, 0);
    rd_reg(3'd4, v);
    step(20);
    rd_reg(3'd4, v); check("R6 period zero", v[0], 0);

    // R9 mask set/clear
    wr_reg(3'd5, 32'h9); rd_reg(3'd7, v); check("R9 set 9", v, 32'h9);
    wr_reg(3'd5, 32'h4); rd_reg(3'd7, v); check("R9 set 4", v, 32'hD);
    wr_reg(3'd6, 32'h1); rd_reg(3'd7, v); check("R9 clr 1", v, 32'hC);
    wr_reg(3'd5, 32'h0); rd_reg(3'd7, v); check("R9 set 0", v, 32'hC);
    wr_reg(3'd6, 32'h0); rd_reg(3'd7, v); check("R9 clr 0", v, 32'hC);
    wr_reg(3'd6, 32'hF); rd_reg(3'd7, v); check("R9 clr all", v, 32'h0);

    // R10 interrupt gating
    wr_reg(3'd5, 32'h8);
    rd_reg(3'd4, v);
    check("R10 idle", irq, 0);
    step(1);
    check("R10 unmasked step", irq, 0);
    rd_reg(3'd0, c);
    wr_reg(3'd1, (c + 2) & CMASK);
    step(2);
    check("R10 alarm irq", irq, 1);
    rd_reg(3'd4, v);
    check("R10 irq after read", irq, 0);
    step(1);
    check("R10 step masked", irq, 0);
    wr_reg(3'd5, 32'h4);
    check("R10 unmask pending", irq, 1);
    wr_reg(3'd6, 32'h4);
    check("R10 mask again", irq, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule